// File: doc/BRIEF.md
# Serial Converter Chain Readout Controller

This block is the host-side master for a string of 16-bit sampling converters wired in a daisy chain. All converters share one convert strobe and one serial clock. Their data outputs pass from device to device, so only the device nearest the host drives the single return line. The controller holds the chain-select line low whenever it raises the convert strobe, which puts every device into chained shifting. It then waits a fixed conversion time with the serial clock idle. After that it issues N_DEV×16 serial-clock pulses while the strobe is still high.

One bit is captured at each falling edge of the serial clock. Every group of 16 bits is packed into one word, most significant bit first, and the word is handed out on a valid/data stream tagged with its device index. The nearest device is index 0 and comes out first. A frame-done pulse marks the word from the farthest device.

A conversion starts on a one-cycle start request, or on each tick of an internal rate counter while free-running is enabled. A request that comes before the minimum cycle time has passed is held, and it is served on the first cycle that the spacing rule allows. Clock division, conversion time, minimum cycle time, rate and chain length are all parameters, in units of the system clock.

Top module: `adc_chain_reader`

## Requirements
- R1: `chain_sel_o` is low on every cycle in which `conv_o` rises, so the whole chain enters chained shifting.
- R2: A one-cycle `start_i` pulse in an idle, spacing-satisfied state raises `conv_o` on the next clock edge. While `free_run_i` is high, conversions start every RATE_CYC cycles.
- R3: Two rising edges of `conv_o` are never less than CYCLE_MIN cycles apart. A request made earlier than that is held, and it is served exactly CYCLE_MIN cycles after the previous rise.
- R4: `ser_clk_o` stays low for the conversion wait. Its first rising edge in a frame comes exactly CONV_CYC+SCLK_HALF cycles after `conv_o` rises.
- R5: During shifting, each high phase and each low phase of `ser_clk_o` lasts SCLK_HALF cycles. Each frame has exactly N_DEV×16 falling edges, and `conv_o` falls on the edge of the last one.
- R6: `chain_dat_i` is sampled on each clock edge at which `ser_clk_o` falls. Each run of 16 samples forms one word, the first sample in bit 15 and the last in bit 0 (two's-complement code passed unchanged).
- R7: `word_valid_o` is a one-cycle pulse per word. Word indices in a frame run 0,1,…,N_DEV−1, and index 0 carries the device nearest the host.
- R8: `frame_done_o` is high only together with the word of index N_DEV−1.
- R9: After reset, `conv_o`, `ser_clk_o`, `chain_sel_o`, `word_valid_o` and `frame_done_o` are all low.
- R10: With no start request and free-running off, no conversion begins. `ser_clk_o` is never high while `conv_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle conversion request |
| free_run_i | input | 1 | Enables periodic conversions at RATE_CYC |
| chain_dat_i | input | 1 | Serial data returned by the nearest device |
| conv_o | output | 1 | Convert strobe; high through conversion and readout |
| ser_clk_o | output | 1 | Serial shift clock to all devices |
| chain_sel_o | output | 1 | Chain-select level, held low |
| word_valid_o | output | 1 | Word strobe |
| word_data_o | output | 16 | Captured word, MSB first on the wire |
| word_idx_o | output | idx_bits(N_DEV) | Device index of the word |
| frame_done_o | output | 1 | Marks the last word of a frame |

## Verification
A start pulse presented before a clock edge shows up as a rising `conv_o` after that same edge. The first serial-clock rise follows CONV_CYC+SCLK_HALF cycles later. Each word strobe appears one edge after the 16th captured falling edge. The bench keeps a free-running cycle count that advances on rising edges and reads the outputs only on falling edges, so every latency and spacing is compared as an exact difference of that count (1, CONV_CYC+SCLK_HALF, CYCLE_MIN, RATE_CYC). A behavioural chain of shift registers reacts to the controller's own strobe and clock, and a scoreboard queue filled before each conversion is compared in order against the word strobes as they arrive.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

    localparam int WORD_BITS = 16;

    typedef enum logic [1:0] {
        SEQ_ACQ   = 2'd0,
        SEQ_CONV  = 2'd1,
        SEQ_SHIFT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic                 valid;
        logic                 last;
        logic [WORD_BITS-1:0] data;
    } word_beat_t;

    // bits needed to hold values 0..limit
    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    // bits needed to index n items
    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/adcc_pacer.sv
module adcc_pacer
    import adcc_pkg::*;
#(
    parameter int CYCLE_MIN = 800,
    parameter int RATE_CYC  = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic free_run_i,
    input  logic idle_i,
    output logic launch_o
);
    localparam int SW = cnt_bits(CYCLE_MIN);
    localparam int RW = cnt_bits(RATE_CYC);
    localparam logic [SW-1:0] SINCE_FULL = SW'(CYCLE_MIN);
    localparam logic [RW-1:0] RATE_LAST  = RW'(RATE_CYC - 1);

    logic [SW-1:0] since_q;
    logic [RW-1:0] rate_q;
    logic          pend_q;
    logic          tick;
    logic          want;

    assign tick     = free_run_i && (rate_q == RATE_LAST);
    assign want     = pend_q | start_i | tick;
    assign launch_o = want && idle_i && (since_q == SINCE_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= SINCE_FULL;
            rate_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (!free_run_i || tick)
                rate_q <= '0;
            else
                rate_q <= rate_q + 1'b1;

            pend_q <= want & ~launch_o;

            if (launch_o)
                since_q <= SW'(1);
            else if (since_q != SINCE_FULL)
                since_q <= since_q + 1'b1;
        end
    end
endmodule

// File: rtl/adcc_sequencer.sv
module adcc_sequencer
    import adcc_pkg::*;
#(
    parameter int CONV_CYC   = 440,
    parameter int SCLK_HALF  = 2,
    parameter int TOTAL_BITS = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic launch_i,
    output logic conv_o,
    output logic ser_clk_o,
    output logic idle_o,
    output logic fall_o
);
    localparam int WW = cnt_bits(CONV_CYC);
    localparam int HW = cnt_bits(SCLK_HALF);
    localparam int BW = cnt_bits(TOTAL_BITS);
    localparam logic [WW-1:0] WAIT_LAST = WW'(CONV_CYC - 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(SCLK_HALF - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(TOTAL_BITS - 1);

    seq_state_e    state_q;
    logic [WW-1:0] wait_q;
    logic [HW-1:0] half_q;
    logic [BW-1:0] bits_q;

    assign idle_o = (state_q == SEQ_ACQ);
    assign fall_o = (state_q == SEQ_SHIFT) && ser_clk_o && (half_q == HALF_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_ACQ;
            conv_o    <= 1'b0;
            ser_clk_o <= 1'b0;
            wait_q    <= '0;
            half_q    <= '0;
            bits_q    <= '0;
        end else begin
            unique case (state_q)
                SEQ_ACQ: begin
                    if (launch_i) begin
                        state_q <= SEQ_CONV;
                        conv_o  <= 1'b1;
                        wait_q  <= '0;
                    end
                end
                SEQ_CONV: begin
                    if (wait_q == WAIT_LAST) begin
                        state_q   <= SEQ_SHIFT;
                        half_q    <= '0;
                        bits_q    <= '0;
                        ser_clk_o <= 1'b0;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                SEQ_SHIFT: begin
                    if (half_q == HALF_LAST) begin
                        half_q    <= '0;
                        ser_clk_o <= ~ser_clk_o;
                        if (ser_clk_o) begin
                            bits_q <= bits_q + 1'b1;
                            if (bits_q == BIT_LAST) begin
                                state_q <= SEQ_ACQ;
                                conv_o  <= 1'b0;
                            end
                        end
                    end else begin
                        half_q <= half_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_ACQ;
            endcase
        end
    end
endmodule

// File: rtl/adcc_deserializer.sv
module adcc_deserializer
    import adcc_pkg::*;
#(
    parameter int N_DEV = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frame_start_i,
    input  logic                       fall_i,
    input  logic                       bit_i,
    output word_beat_t                 beat_o,
    output logic [idx_bits(N_DEV)-1:0] idx_o
);
    localparam int IW = idx_bits(N_DEV);
    localparam int PW = cnt_bits(WORD_BITS - 1);
    localparam logic [IW-1:0] DEV_LAST = IW'(N_DEV - 1);
    localparam logic [PW-1:0] POS_LAST = PW'(WORD_BITS - 1);

    logic [WORD_BITS-1:0] shreg_q;
    logic [PW-1:0]        pos_q;
    logic [IW-1:0]        dev_q;
    logic [WORD_BITS-1:0] next_word;

    assign next_word = {shreg_q[WORD_BITS-2:0], bit_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            pos_q   <= '0;
            dev_q   <= '0;
            beat_o  <= '0;
            idx_o   <= '0;
        end else begin
            beat_o.valid <= 1'b0;
            beat_o.last  <= 1'b0;
            if (frame_start_i) begin
                pos_q <= '0;
                dev_q <= '0;
            end else if (fall_i) begin
                shreg_q <= next_word;
                if (pos_q == POS_LAST) begin
                    pos_q        <= '0;
                    beat_o.valid <= 1'b1;
                    beat_o.last  <= (dev_q == DEV_LAST);
                    beat_o.data  <= next_word;
                    idx_o        <= dev_q;
                    dev_q        <= (dev_q == DEV_LAST) ? '0 : dev_q + 1'b1;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader
    import adcc_pkg::*;
#(
    parameter int N_DEV     = 3,
    parameter int CONV_CYC  = 440,
    parameter int SCLK_HALF = 2,
    parameter int CYCLE_MIN = 800,
    parameter int RATE_CYC  = 1000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic                       free_run_i,
    input  logic                       chain_dat_i,
    output logic                       conv_o,
    output logic                       ser_clk_o,
    output logic                       chain_sel_o,
    output logic                       word_valid_o,
    output logic [WORD_BITS-1:0]       word_data_o,
    output logic [idx_bits(N_DEV)-1:0] word_idx_o,
    output logic                       frame_done_o
);
    localparam int TOTAL_BITS = N_DEV * WORD_BITS;

    logic       launch;
    logic       idle;
    logic       fall;
    word_beat_t beat;

    assign chain_sel_o = 1'b0;

    adcc_pacer #(
        .CYCLE_MIN (CYCLE_MIN),
        .RATE_CYC  (RATE_CYC)
    ) pacer_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .free_run_i (free_run_i),
        .idle_i     (idle),
        .launch_o   (launch)
    );

    adcc_sequencer #(
        .CONV_CYC   (CONV_CYC),
        .SCLK_HALF  (SCLK_HALF),
        .TOTAL_BITS (TOTAL_BITS)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .launch_i  (launch),
        .conv_o    (conv_o),
        .ser_clk_o (ser_clk_o),
        .idle_o    (idle),
        .fall_o    (fall)
    );

    adcc_deserializer #(
        .N_DEV (N_DEV)
    ) deser_i (
        .clk           (clk),
        .rst           (rst),
        .frame_start_i (launch),
        .fall_i        (fall),
        .bit_i         (chain_dat_i),
        .beat_o        (beat),
        .idx_o         (word_idx_o)
    );

    assign word_valid_o = beat.valid;
    assign word_data_o  = beat.data;
    assign frame_done_o = beat.last;
endmodule

// File: rtl/adc_chain_reader_chk.sv
module adc_chain_reader_chk
    import adcc_pkg::*;
#(
    parameter int N_DEV     = 3,
    parameter int CONV_CYC  = 440,
    parameter int SCLK_HALF = 2,
    parameter int CYCLE_MIN = 800
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       conv_o,
    input logic                       ser_clk_o,
    input logic                       chain_sel_o,
    input logic                       word_valid_o,
    input logic [idx_bits(N_DEV)-1:0] word_idx_o,
    input logic                       frame_done_o
);
    localparam int GW = cnt_bits(CYCLE_MIN);
    localparam int CW = cnt_bits(CONV_CYC);
    localparam int HW = cnt_bits(SCLK_HALF + 1);
    localparam int IW = idx_bits(N_DEV);

    logic [GW-1:0] gap_q;
    logic [CW-1:0] since_q;
    logic [HW-1:0] hold_q;
    logic          conv_d;
    logic          sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= GW'(CYCLE_MIN);
            since_q <= '0;
            hold_q  <= HW'(SCLK_HALF + 1);
            conv_d  <= 1'b0;
            sclk_d  <= 1'b0;
        end else begin
            conv_d <= conv_o;
            sclk_d <= ser_clk_o;
            if (conv_o && !conv_d) begin
                gap_q   <= GW'(1);
                since_q <= CW'(1);
            end else begin
                if (gap_q != GW'(CYCLE_MIN)) gap_q <= gap_q + 1'b1;
                if (since_q != CW'(CONV_CYC)) since_q <= since_q + 1'b1;
            end
            if (ser_clk_o != sclk_d)
                hold_q <= HW'(1);
            else if (hold_q != HW'(SCLK_HALF + 1))
                hold_q <= hold_q + 1'b1;
        end
    end

    a_r1_sel_low_at_convert: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_o) |-> !chain_sel_o);

    a_r3_min_spacing: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_o) |-> (gap_q >= GW'(CYCLE_MIN)));

    a_r4_quiet_conversion: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk_o) |-> (since_q >= CW'(CONV_CYC)));

    a_r5_high_phase: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_clk_o) |-> (hold_q == HW'(SCLK_HALF)));

    a_r5_low_phase: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk_o) |-> (hold_q >= HW'(SCLK_HALF)));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);

    a_r8_done_on_last: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> (word_valid_o && (word_idx_o == IW'(N_DEV - 1))));

    a_r10_clock_in_frame: assert property (@(posedge clk) disable iff (rst)
        ser_clk_o |-> conv_o);
endmodule

bind adc_chain_reader adc_chain_reader_chk #(
    .N_DEV     (N_DEV),
    .CONV_CYC  (CONV_CYC),
    .SCLK_HALF (SCLK_HALF),
    .CYCLE_MIN (CYCLE_MIN)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .conv_o       (conv_o),
    .ser_clk_o    (ser_clk_o),
    .chain_sel_o  (chain_sel_o),
    .word_valid_o (word_valid_o),
    .word_idx_o   (word_idx_o),
    .frame_done_o (frame_done_o)
);

// File: tb/adc_chain_reader_tb_top.sv
module adc_chain_reader_tb_top;
    localparam int N_DEV     = 3;
    localparam int CONV_CYC  = 440;
    localparam int SCLK_HALF = 2;
    localparam int CYCLE_MIN = 800;
    localparam int RATE_CYC  = 1000;
    localparam int IW        = (N_DEV < 2) ? 1 : $clog2(N_DEV);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          free_run_i = 1'b0;
    logic          chain_dat_i;
    logic          conv_o, ser_clk_o, chain_sel_o;
    logic          word_valid_o, frame_done_o;
    logic [15:0]   word_data_o;
    logic [IW-1:0] word_idx_o;

    always #2.5 clk = ~clk;

    adc_chain_reader #(
        .N_DEV(N_DEV), .CONV_CYC(CONV_CYC), .SCLK_HALF(SCLK_HALF),
        .CYCLE_MIN(CYCLE_MIN), .RATE_CYC(RATE_CYC)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .free_run_i(free_run_i),
        .chain_dat_i(chain_dat_i), .conv_o(conv_o), .ser_clk_o(ser_clk_o),
        .chain_sel_o(chain_sel_o), .word_valid_o(word_valid_o),
        .word_data_o(word_data_o), .word_idx_o(word_idx_o),
        .frame_done_o(frame_done_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // behavioural chain of converters
    logic [15:0] next_samp [N_DEV];
    logic [15:0] dev_sh    [N_DEV];
    assign chain_dat_i = dev_sh[0][15];

    initial for (int k = 0; k < N_DEV; k++) dev_sh[k] = 16'h0;

    always @(posedge conv_o) begin
        chk(chain_sel_o == 1'b0, "R1", "chain select at convert", chain_sel_o, 0);
        for (int k = 0; k < N_DEV; k++) dev_sh[k] <= next_samp[k];
    end

    always @(negedge ser_clk_o) begin
        for (int k = 0; k < N_DEV; k++)
            dev_sh[k] <= {dev_sh[k][14:0],
                          (k == N_DEV - 1) ? chain_sel_o : dev_sh[(k + 1) % N_DEV][15]};
    end

    // scoreboard
    logic [15:0] exp_data[$];
    int          exp_idx[$];
    int          words_seen = 0;

    task automatic load_samples(input logic [15:0] s0, input logic [15:0] s1,
                                input logic [15:0] s2);
        logic [15:0] v [3];
        v[0] = s0; v[1] = s1; v[2] = s2;
        for (int k = 0; k < N_DEV; k++) begin
            next_samp[k] = v[k % 3] ^ 16'(k / 3);
            exp_data.push_back(next_samp[k]);
            exp_idx.push_back(k);
        end
    endtask

    // timing tracker and monitor, sampled on falling clock edges
    int  rise_t[$];
    int  fall_cnt_q[$];
    int  first_off_q[$];
    int  falls_cur = 0;
    int  first_off = -1;
    int  conv_falls = 0;
    int  sclk_rises = 0;
    logic conv_p = 1'b0, sclk_p = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (conv_o && !conv_p) begin
                rise_t.push_back(cyc);
                falls_cur = 0;
                first_off = -1;
            end
            if (ser_clk_o && !sclk_p) begin
                sclk_rises++;
                if (first_off < 0) first_off = cyc - rise_t[$];
            end
            if (!ser_clk_o && sclk_p) falls_cur++;
            if (!conv_o && conv_p) begin
                fall_cnt_q.push_back(falls_cur);
                first_off_q.push_back(first_off);
                conv_falls++;
            end
            if (word_valid_o) begin
                words_seen++;
                if (exp_data.size() == 0) begin
                    chk(1'b0, "R6", "unexpected word", word_data_o, -1);
                end else begin
                    logic [15:0] ed;
                    int ei;
                    ed = exp_data.pop_front();
                    ei = exp_idx.pop_front();
                    chk(word_data_o == ed, "R6", "word data", word_data_o, ed);
                    chk(int'(word_idx_o) == ei, "R7", "word index", word_idx_o, ei);
                    chk(frame_done_o == (ei == N_DEV - 1), "R8", "frame done with word",
                        frame_done_o, (ei == N_DEV - 1));
                end
            end else if (frame_done_o) begin
                chk(1'b0, "R8", "frame done without word", 1, 0);
            end
            conv_p = conv_o;
            sclk_p = ser_clk_o;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wait_frames(input int n);
        while (conv_falls < n) @(posedge clk);
        @(negedge clk);
        chk(fall_cnt_q[n-1] == N_DEV * 16, "R5", "falls per frame",
            fall_cnt_q[n-1], N_DEV * 16);
        chk(first_off_q[n-1] == CONV_CYC + SCLK_HALF, "R4", "first clock offset",
            first_off_q[n-1], CONV_CYC + SCLK_HALF);
    endtask

    int start_cyc;
    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R5", "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (10) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(conv_o == 1'b0, "R9", "conv after reset", conv_o, 0);
        chk(ser_clk_o == 1'b0, "R9", "clock after reset", ser_clk_o, 0);
        chk(chain_sel_o == 1'b0, "R9", "select after reset", chain_sel_o, 0);
        chk(word_valid_o == 1'b0, "R9", "valid after reset", word_valid_o, 0);
        chk(frame_done_o == 1'b0, "R9", "done after reset", frame_done_o, 0);

        // R10 no request, no conversion
        repeat (1500) @(negedge clk);
        chk(rise_t.size() == 0, "R10", "conversions without request", rise_t.size(), 0);
        chk(sclk_rises == 0, "R10", "clock pulses without request", sclk_rises, 0);

        // frame 1: extreme codes, start latency
        load_samples(16'h8000, 16'h7FFF, 16'h0001);
        pulse_start();
        wait_frames(1);
        chk(rise_t[0] - start_cyc == 1, "R2", "start to convert latency",
            rise_t[0] - start_cyc, 1);

        // frame 2: early request held until spacing is met
        load_samples(16'hA5A5, 16'h5A5A, 16'hFFFF);
        pulse_start();
        wait_frames(2);
        chk(rise_t[1] - rise_t[0] == CYCLE_MIN, "R3", "held request spacing",
            rise_t[1] - rise_t[0], CYCLE_MIN);

        // frame 3: late request after long idle
        repeat (2000) @(negedge clk);
        load_samples(16'h0000, 16'h1234, 16'hFEDC);
        pulse_start();
        wait_frames(3);
        chk(rise_t[2] - start_cyc == 1, "R2", "late start latency",
            rise_t[2] - start_cyc, 1);

        // frames 4..6: free-running
        free_run_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            load_samples(16'(16'h1111 * (i + 1)), 16'(16'h8001 + i), 16'(16'h00FF << i));
            wait_frames(4 + i);
        end
        free_run_i = 1'b0;
        chk(rise_t[4] - rise_t[3] == RATE_CYC, "R2", "free-run period",
            rise_t[4] - rise_t[3], RATE_CYC);
        chk(rise_t[5] - rise_t[4] == RATE_CYC, "R2", "free-run period",
            rise_t[5] - rise_t[4], RATE_CYC);

        repeat (1500) @(negedge clk);
        chk(rise_t.size() == 6, "R10", "no conversion after free-run off", rise_t.size(), 6);
        chk(exp_data.size() == 0, "R7", "words left unseen", exp_data.size(), 0);
        chk(words_seen == 6 * N_DEV, "R7", "word count", words_seen, 6 * N_DEV);
        finish_run();
    end
endmodule